// File: doc/BRIEF.md
# Quad Channel Latch Bus Decoder

This block sits between a shared 8-bit data port and four channel data latches, which are called A, B, C and D and are indexed 0 to 3. Two active-low select lines choose the channel group. A pair-select bit chooses one channel within that group. A direction bit chooses between writing the latches and reading one of them back. These four control lines decode into one write strobe per latch and a one-hot readback select.

A latch whose strobe is active loads the incoming bus value on every clock edge, so it follows the bus for as long as the write lasts. When the strobe drops, the latch holds the last value it took. With both selects low in write mode, two latches load together: A and C, or B and D. A readback puts the contents of one selected latch on `data_out` and raises `data_oe`, which an outer pad ring uses to control its tri-state driver. All four latches are presented at all times on a parallel output for downstream converters.

Top module: `qlb_bus_if`

## Requirements
- R1: With `sel0_n`=0, `sel1_n`=1 and `rd_wr`=0, the bus value is loaded into channel A (index 0) when `pair_sel`=1, or into channel B (index 1) when `pair_sel`=0, at the next rising clock edge. No other channel changes.
- R2: With `sel0_n`=1, `sel1_n`=0 and `rd_wr`=0, the bus value is loaded into channel C (index 2) when `pair_sel`=1, or into channel D (index 3) when `pair_sel`=0. No other channel changes.
- R3: With both selects low and `rd_wr`=0, channels A and C load together when `pair_sel`=1, and channels B and D load together when `pair_sel`=0.
- R4: With both selects low and `rd_wr`=1, no channel changes and `data_oe` stays 0.
- R5: With both selects high, no channel changes and `data_oe` stays 0, whatever the values of `pair_sel` and `rd_wr`.
- R6: While a write mode persists, the selected latch takes the current bus value at every rising edge, so its output tracks the bus one cycle later.
- R7: After the write mode ends, the latch keeps the last value loaded, even when `data_in` changes afterwards.
- R8: With exactly one select low and `rd_wr`=1, `data_oe` is 1 and `data_out` equals the selected channel's latch, using the same channel mapping as R1 and R2.
- R9: Whenever `data_oe` is 0, `data_out` is all zeros.
- R10: `chan_q[i]` shows latch i's contents in every mode, reads included.
- R11: While `rst_n` is low at a rising edge, all latches clear to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel0_n | input | 1 | Active-low select, group A/B |
| sel1_n | input | 1 | Active-low select, group C/D |
| pair_sel | input | 1 | 1 picks A or C, 0 picks B or D |
| rd_wr | input | 1 | 1 = read, 0 = write |
| data_in | input | W | Bus data toward the latches |
| data_out | output | W | Readback data, zero when idle |
| data_oe | output | 1 | Readback driver enable |
| chan_q | output | 4×W | Parallel latch contents, index = channel |

## Verification
On every cycle, assertions check several properties. Each latch either loads the previous bus value or stays stable, depending on its strobe. The readback select is at most one-hot. `data_oe` rises only for a single-select read. A dual-select write strobes exactly two latches. An idle `data_out` is zero. Only the bench's scenarios can show that the decode follows the mode table: which channel each of the 16 control combinations reaches, that a latch tracks the bus across several cycles of one write, that it retains its value after the write ends, and that reset clears all latches.

// File: rtl/qlb_pkg.sv
package qlb_pkg;
   localparam int NCH   = 4;
   localparam int CH_A  = 0;
   localparam int CH_B  = 1;
   localparam int CH_C  = 2;
   localparam int CH_D  = 3;
   localparam int IDX_W = $clog2(NCH);

   typedef enum logic [1:0] {
      GRP_NONE = 2'd0,
      GRP_LO   = 2'd1,
      GRP_HI   = 2'd2,
      GRP_BOTH = 2'd3
   } grp_e;
endpackage

// File: rtl/qlb_decode.sv
module qlb_decode
   import qlb_pkg::*;
(
   input  logic           sel0_n,
   input  logic           sel1_n,
   input  logic           pair_sel,
   input  logic           rd_wr,
   output logic [NCH-1:0] wen,
   output logic [NCH-1:0] rd_sel
);
   grp_e grp;

   always_comb begin
      grp = grp_e'({~sel1_n, ~sel0_n});
   end

   always_comb begin
      wen    = '0;
      rd_sel = '0;
      if (!rd_wr) begin
         // write: the low group covers A/B, the high group covers C/D, both covers the pairs
         if (grp == GRP_LO || grp == GRP_BOTH) begin
            wen[CH_A] = pair_sel;
            wen[CH_B] = ~pair_sel;
         end
         if (grp == GRP_HI || grp == GRP_BOTH) begin
            wen[CH_C] = pair_sel;
            wen[CH_D] = ~pair_sel;
         end
      end else begin
         // read: only a single group may drive back
         if (grp == GRP_LO) begin
            rd_sel[CH_A] = pair_sel;
            rd_sel[CH_B] = ~pair_sel;
         end
         if (grp == GRP_HI) begin
            rd_sel[CH_C] = pair_sel;
            rd_sel[CH_D] = ~pair_sel;
         end
      end
   end
endmodule

// File: rtl/qlb_latch.sv
module qlb_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wen,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= '0;
      else if (wen) q <= d;
   end

   // R6: an active strobe loads the bus value at the edge
   p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wen |=> q == $past(d));
   // R7: without a strobe the contents stay put
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wen |=> $stable(q));
endmodule

// File: rtl/qlb_rdmux.sv
module qlb_rdmux
   import qlb_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [NCH-1:0]        rd_sel,
   input  logic [NCH-1:0][W-1:0] q,
   output logic [W-1:0]          dout,
   output logic                  oe
);
   always_comb begin
      dout = '0;
      for (int i = 0; i < NCH; i++) begin
         if (rd_sel[i]) dout = dout | q[i];
      end
      oe = |rd_sel;
   end
endmodule

// File: rtl/qlb_bus_if.sv
module qlb_bus_if
   import qlb_pkg::*;
#(
   parameter int W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sel0_n,
   input  logic                  sel1_n,
   input  logic                  pair_sel,
   input  logic                  rd_wr,
   input  logic [W-1:0]          data_in,
   output logic [W-1:0]          data_out,
   output logic                  data_oe,
   output logic [NCH-1:0][W-1:0] chan_q
);
   generate
      if (W < 1) begin : g_bad_width
         $error("qlb_bus_if: W must be at least 1");
      end
      if (NCH != 4) begin : g_bad_count
         $error("qlb_bus_if: decode assumes four channels");
      end
   endgenerate

   logic [NCH-1:0] wen;
   logic [NCH-1:0] rd_sel;

   qlb_decode u_dec (
      .sel0_n  (sel0_n),
      .sel1_n  (sel1_n),
      .pair_sel(pair_sel),
      .rd_wr   (rd_wr),
      .wen     (wen),
      .rd_sel  (rd_sel)
   );

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_ch
         qlb_latch #(.W(W)) u_lat (
            .clk  (clk),
            .rst_n(rst_n),
            .wen  (wen[g]),
            .d    (data_in),
            .q    (chan_q[g])
         );
      end
   endgenerate

   qlb_rdmux #(.W(W)) u_rd (
      .rd_sel(rd_sel),
      .q     (chan_q),
      .dout  (data_out),
      .oe    (data_oe)
   );

   // R8: at most one latch is ever chosen for readback
   p_onehot_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_sel));
   // R8/R4/R5: the driver turns on only for a single-select read
   p_oe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> (rd_wr && (sel0_n != sel1_n)));
   // R9: an idle bus output is zero
   p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !data_oe |-> data_out == '0);
   // R3: a dual-select write strobes exactly two latches
   p_pair_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel0_n && !sel1_n && !rd_wr) |-> $countones(wen) == 2);
   // R5: both selects high leave every latch unchanged
   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel0_n && sel1_n) |=> $stable(chan_q));
endmodule

// File: tb/qlb_bus_if_tb.sv
module qlb_bus_if_tb_top;
   localparam time CLK_PERIOD = 10ns;
   localparam int  W = 8;

   // entry: {sel0_n, sel1_n, pair_sel, rd_wr, write mask[3:0], oe, read channel[1:0]}
   localparam logic [10:0] VEC [16] = '{
      11'b0000_1010_0_00, 11'b0001_0000_0_00, 11'b0010_0101_0_00, 11'b0011_0000_0_00,
      11'b0100_0010_0_00, 11'b0101_0000_1_01, 11'b0110_0001_0_00, 11'b0111_0000_1_00,
      11'b1000_1000_0_00, 11'b1001_0000_1_11, 11'b1010_0100_0_00, 11'b1011_0000_1_10,
      11'b1100_0000_0_00, 11'b1101_0000_0_00, 11'b1110_0000_0_00, 11'b1111_0000_0_00
   };

   logic clk = 1'b0;
   logic rst_n, sel0_n, sel1_n, pair_sel, rd_wr;
   logic [W-1:0] data_in, data_out;
   logic data_oe;
   logic [3:0][W-1:0] chan_q;
   logic [3:0][W-1:0] exp_q;
   int nvec = 0, nfail = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   qlb_bus_if #(.W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .sel0_n(sel0_n), .sel1_n(sel1_n),
      .pair_sel(pair_sel), .rd_wr(rd_wr), .data_in(data_in),
      .data_out(data_out), .data_oe(data_oe), .chan_q(chan_q)
   );

   task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [3:0] c);
      if (c[3] && c[2]) return "R5";
      if (!c[3] && !c[2]) return c[0] ? "R4" : "R3";
      if (c[0]) return "R8";
      return c[3] ? "R2" : "R1";
   endfunction

   task automatic step(input logic [3:0] c, input logic [W-1:0] d);
      @(negedge clk);
      {sel0_n, sel1_n, pair_sel, rd_wr} = c;
      data_in = d;
      @(negedge clk);
   endtask

   task automatic check_all(input string req);
      for (int k = 0; k < 4; k++) chk(chan_q[k], exp_q[k], req);
   endtask

   initial begin
      repeat (3000) @(posedge clk);
      if (!finished) begin
         nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; sel0_n = 1'b1; sel1_n = 1'b1; pair_sel = 1'b0; rd_wr = 1'b1;
      data_in = 8'hFF;
      exp_q = '0;
      repeat (2) @(negedge clk);
      check_all("R11");
      chk(W'(data_oe), 8'h00, "R11");
      rst_n = 1'b1;

      // table walk over all control combinations
      for (int i = 0; i < 16; i++) begin
         logic [3:0] c;
         logic [W-1:0] d;
         c = VEC[i][10:7];
         d = W'(8'h3C + 8'd17 * i[7:0]);
         step(c, d);
         for (int k = 0; k < 4; k++) if (VEC[i][3+k]) exp_q[k] = d;
         check_all(tag_of(c));
         chk(W'(data_oe), W'(VEC[i][2]), tag_of(c));
         chk(data_out, VEC[i][2] ? exp_q[VEC[i][1:0]] : '0, VEC[i][2] ? "R8" : "R9");
      end

      // R6: channel D follows the bus over several cycles of one write
      for (int j = 0; j < 4; j++) begin
         step(4'b1000, W'(8'h90 + j[7:0]));
         exp_q[3] = W'(8'h90 + j[7:0]);
         chk(chan_q[3], exp_q[3], "R6");
      end
      // R7: leaving write mode, new bus data is ignored
      step(4'b1001, 8'h5A);
      chk(chan_q[3], exp_q[3], "R7");
      chk(data_out, exp_q[3], "R7 readback");
      step(4'b1101, 8'hC3);
      chk(chan_q[3], exp_q[3], "R7");
      // R10: parallel outputs stay valid during a read of another channel
      step(4'b0111, 8'h00);
      check_all("R10");
      chk(data_out, exp_q[0], "R8");
      // R5: both selects high with write direction
      step(4'b1100, 8'hEE);
      check_all("R5");
      // R4: dual select in read mode drives nothing
      step(4'b0011, 8'hEE);
      check_all("R4");
      chk(data_out, 8'h00, "R9");
      // R11: reset mid-run clears every latch
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      exp_q = '0;
      check_all("R11");

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule